// File: doc/BRIEF.md
# Infrared Pulse-Width Receiver with Carrier Demodulation

This block times the mark and space intervals seen on an infrared receive line and queues each measured interval in a small FIFO that a host drains. A divider turns the reference clock into measurement ticks. A width timer counts those ticks in groups of four. Selected transitions of the line start the timer, and each later selected transition stops it and starts it again. Each stored word holds the interval length and the level that held during that interval.

Before timing, the line passes through a two-flop synchronizer and an optional minimum-width filter. A loopback selector can feed the transmitter output into the receiver in place of the external pin. When demodulation is on, the receiver does not time the raw line. It times a recovered mark signal instead. A mark is declared while rising carrier edges keep arriving about 16 ticks apart, inside a tolerance window that can be chosen.

If no terminating edge arrives before the count saturates, the timer stops. It stores a reserved all-ones timeout word, unless that store is suppressed. Status flags report a FIFO service request, a timeout, an overrun and a busy timer. Each flag can drive the interrupt output through its own enable.

Top module: `ir_pw_rx`

## Requirements
- R1: With `clk_div` = D, a tick occurs every D+1 clocks. The stored count is the number of completed 4-tick groups between the starting edge and the terminating edge. With D = 0 and the two edges K clocks apart at the input, the count is floor((K-1)/4).
- R2: `edge_sel` chooses which transitions start and stop the timer: 00 none, 01 falling, 10 rising, 11 both. With 00, no word is ever stored and `busy` stays low.
- R3: The read word holds the count in bits CNT_W-1:0. Bit CNT_W holds the level that was present just before the terminating edge, with 1 meaning mark. Bit CNT_W+1 is 1 exactly when the FIFO holds data. The `rd_en` input pops one word.
- R4: If the count is at its maximum when another 4-tick group completes, the timer stops and `busy` falls. The word with count all ones and level bit 1 is stored, and `timeout` is set.
- R5: When `no_load` is 1, a timer overflow stores nothing, but it still sets `timeout`.
- R6: The FIFO holds DEPTH words (8 by default). `svc_req` is high when the FIFO holds DEPTH/2 or more words. If `wm_not_empty` is 1, `svc_req` is instead high when the FIFO holds any word.
- R7: A word written into a full FIFO is dropped and sets the sticky `overrun` flag. Driving `fifo_en` low empties the FIFO and clears `overrun`.
- R8: Driving `rx_en` low stops the timer and clears `timeout`.
- R9: With `lpf_count` = L > 0, the input must hold a new level for L clocks before the receiver accepts it. A shorter pulse is discarded. With L = 0 the filter is bypassed.
- R10: With `loopback` = 1, the receiver listens to `tx_loop_in` and ignores `ir_in`.
- R11: With demodulation on, a rising carrier edge that arrives 13 to 19 ticks after the previous one sets the mark. `win_sel` bit 0 lowers the early limit to 12 ticks.
- R12: The mark clears when a tick brings the spacing since the last carrier edge past the late limit. The late limit is 19 ticks, or 20 ticks when `win_sel` bit 1 is set. A spacing outside the window never starts a mark.
- R13: `irq` is registered. It equals (`svc_req` AND `svc_ie`) OR (`timeout` AND `to_ie`) OR (`overrun` AND `ovr_ie`) from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | External infrared line |
| tx_loop_in | input | 1 | Transmitter output used in loopback |
| loopback | input | 1 | Selects tx_loop_in as the receive source |
| rx_en | input | 1 | Receiver enable; low stops the timer and clears the timeout flag |
| fifo_en | input | 1 | FIFO enable; low flushes the FIFO and clears the overrun flag |
| edge_sel | input | 2 | Timer trigger edges: 00 none, 01 fall, 10 rise, 11 both |
| demod_en | input | 1 | Time the recovered carrier mark instead of the raw line |
| win_sel | input | 2 | Bit 0 widens the early side, bit 1 widens the late side |
| clk_div | input | DIV_W (16) | Tick divider D; one tick every D+1 clocks |
| lpf_count | input | LPF_W (16) | Minimum accepted pulse length in clocks; 0 bypasses the filter |
| no_load | input | 1 | Suppresses the timeout word on overflow |
| wm_not_empty | input | 1 | Service request on any data instead of half full |
| svc_ie | input | 1 | Interrupt enable for the service request |
| to_ie | input | 1 | Interrupt enable for timeout |
| ovr_ie | input | 1 | Interrupt enable for overrun |
| rd_en | input | 1 | Pops the head word |
| rd_data | output | CNT_W+2 (18) | {valid, level, count} of the head word |
| svc_req | output | 1 | FIFO service request |
| timeout | output | 1 | Sticky width-timer overflow flag |
| overrun | output | 1 | Sticky FIFO overrun flag |
| busy | output | 1 | Width timer running |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bound checker verifies several relations on every cycle. A service request never appears while the FIFO is empty. Overrun holds while the FIFO stays enabled. Disabling the FIFO or the receiver clears its flag on the next cycle. A rising timeout always coincides with `busy` falling. The enabled flags reach `irq` one cycle later. The cycle-exact widths, the level bits, the filter rejection of short glitches, loopback source selection and the demodulation window limits can only be shown by the bench. Its scenarios compare every popped word against counts computed from edge spacings.

// File: rtl/ir_pw_pkg.sv
package ir_pw_pkg;
  typedef enum logic [1:0] {
    EDG_OFF  = 2'b00,
    EDG_FALL = 2'b01,
    EDG_RISE = 2'b10,
    EDG_ANY  = 2'b11
  } edge_mode_e;

  localparam int CARRIER_TICKS = 16;
  localparam int TOL_NARROW    = 3;
  localparam int TOL_WIDE      = 4;
endpackage

// File: rtl/ir_pw_input_cond.sv
module ir_pw_input_cond #(
  parameter int LPF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic [LPF_W-1:0] lpf_count,
  output logic             level_out
);
  logic             sync1, sync2;
  logic [LPF_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      level_out <= 1'b0;
      run       <= '0;
    end else begin
      sync1 <= line_in;
      sync2 <= sync1;
      if (lpf_count == '0) begin
        level_out <= sync2;
        run       <= '0;
      end else if (sync2 == level_out) begin
        run <= '0;
      end else if (run == lpf_count - LPF_W'(1)) begin
        level_out <= sync2;
        run       <= '0;
      end else begin
        run <= run + LPF_W'(1);
      end
    end
  end
endmodule

// File: rtl/ir_pw_demod.sv
module ir_pw_demod
  import ir_pw_pkg::*;
#(
  parameter int CARR = CARRIER_TICKS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       tick,
  input  logic       carrier_in,
  input  logic [1:0] win_sel,
  output logic       mark_out
);
  localparam int GAP_W = $clog2(2 * CARR) + 1;
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(2 * CARR - 1);

  logic             car_d;
  logic [GAP_W-1:0] gap, spacing, lo_lim, hi_lim;
  logic             car_edge;

  assign car_edge = carrier_in & ~car_d;
  assign spacing  = gap + GAP_W'(tick);
  assign lo_lim   = GAP_W'(CARR - (win_sel[0] ? TOL_WIDE : TOL_NARROW));
  assign hi_lim   = GAP_W'(CARR + (win_sel[1] ? TOL_WIDE : TOL_NARROW));

  always_ff @(posedge clk) begin
    if (rst) begin
      car_d    <= 1'b0;
      gap      <= GAP_SAT;
      mark_out <= 1'b0;
    end else begin
      car_d <= carrier_in;
      if (!enable) begin
        gap      <= GAP_SAT;
        mark_out <= 1'b0;
      end else if (car_edge) begin
        gap <= '0;
        if (spacing >= lo_lim && spacing <= hi_lim) mark_out <= 1'b1;
      end else if (tick) begin
        if (gap != GAP_SAT) gap <= gap + GAP_W'(1);
        if (spacing > hi_lim) mark_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ir_pw_fifo.sv
module ir_pw_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   wr,
  input  logic [W-1:0]           wdata,
  input  logic                   rd,
  output logic [W-1:0]           rdata,
  output logic [$clog2(DEPTH):0] count,
  output logic                   full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign full  = (count == (AW+1)'(DEPTH));
  assign do_wr = wr && !full;
  assign do_rd = rd && (count != '0);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end
endmodule

// File: rtl/ir_pw_rx.sv
module ir_pw_rx
  import ir_pw_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int LPF_W = 16,
  parameter int CNT_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ir_in,
  input  logic             tx_loop_in,
  input  logic             loopback,
  input  logic             rx_en,
  input  logic             fifo_en,
  input  logic [1:0]       edge_sel,
  input  logic             demod_en,
  input  logic [1:0]       win_sel,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [LPF_W-1:0] lpf_count,
  input  logic             no_load,
  input  logic             wm_not_empty,
  input  logic             svc_ie,
  input  logic             to_ie,
  input  logic             ovr_ie,
  input  logic             rd_en,
  output logic [CNT_W+1:0] rd_data,
  output logic             svc_req,
  output logic             timeout,
  output logic             overrun,
  output logic             busy,
  output logic             irq
);
  localparam int WORD_W = CNT_W + 1;
  localparam int CW     = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DIV_W-1:0]  div_cnt;
  logic              tick, filt, mark, lvl, lvl_d;
  logic              rise, fall, hit, ovf, push;
  logic              running;
  logic [1:0]        quad;
  logic [CNT_W-1:0]  width;
  logic [WORD_W-1:0] push_word, head_word;
  logic [CW-1:0]     fill;
  logic              fifo_full;

  ir_pw_input_cond #(.LPF_W(LPF_W)) u_cond (
    .clk(clk), .rst(rst), .line_in(loopback ? tx_loop_in : ir_in),
    .lpf_count(lpf_count), .level_out(filt)
  );

  ir_pw_demod #(.CARR(CARRIER_TICKS)) u_demod (
    .clk(clk), .rst(rst), .enable(rx_en && demod_en), .tick(tick),
    .carrier_in(filt), .win_sel(win_sel), .mark_out(mark)
  );

  // tick generator
  assign tick = rx_en && (div_cnt == clk_div);
  always_ff @(posedge clk) begin
    if (rst || !rx_en || tick) div_cnt <= '0;
    else                       div_cnt <= div_cnt + DIV_W'(1);
  end

  // width timer
  assign lvl  = demod_en ? mark : filt;
  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
  assign hit  = rx_en && ((edge_sel[1] && rise) || (edge_sel[0] && fall));
  assign ovf  = running && tick && (quad == 2'd3) && (width == CNT_MAX);

  always_comb begin
    push      = 1'b0;
    push_word = '0;
    if (hit && running) begin
      push      = 1'b1;
      push_word = {lvl_d, width};
    end else if (ovf && !no_load) begin
      push      = 1'b1;
      push_word = {1'b1, CNT_MAX};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d   <= 1'b0;
      running <= 1'b0;
      quad    <= '0;
      width   <= '0;
      timeout <= 1'b0;
    end else begin
      lvl_d <= lvl;
      if (!rx_en) begin
        running <= 1'b0;
        timeout <= 1'b0;
      end else if (hit) begin
        running <= 1'b1;
        quad    <= '0;
        width   <= '0;
      end else if (ovf) begin
        running <= 1'b0;
        timeout <= 1'b1;
      end else if (running && tick) begin
        quad <= quad + 2'd1;
        if (quad == 2'd3) width <= width + CNT_W'(1);
      end
    end
  end

  ir_pw_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(!fifo_en), .wr(push && rx_en && fifo_en),
    .wdata(push_word), .rd(rd_en), .rdata(head_word), .count(fill),
    .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst || !fifo_en)                         overrun <= 1'b0;
    else if (push && rx_en && fifo_full)         overrun <= 1'b1;
  end

  assign rd_data = {fill != '0, head_word};
  assign svc_req = wm_not_empty ? (fill != '0) : (fill >= CW'(DEPTH / 2));
  assign busy    = running;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (svc_req && svc_ie) || (timeout && to_ie) || (overrun && ovr_ie);
  end
endmodule

// File: rtl/ir_pw_rx_checker.sv
module ir_pw_rx_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic             fifo_en,
  input logic             svc_ie,
  input logic             to_ie,
  input logic             ovr_ie,
  input logic [CNT_W+1:0] rd_data,
  input logic             svc_req,
  input logic             timeout,
  input logic             overrun,
  input logic             busy,
  input logic             irq
);
  // R6: a service request implies data is present
  assert_svc_has_data_R6: assert property (@(posedge clk) disable iff (rst)
    svc_req |-> rd_data[CNT_W+1]);

  // R7: overrun is sticky while the FIFO stays enabled
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (overrun && fifo_en) |=> overrun);

  // R7: disabling the FIFO flushes it and clears overrun
  assert_fifo_flush_R7: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> (!overrun && !rd_data[CNT_W+1]));

  // R8: disabling the receiver clears timeout and stops the timer
  assert_rx_off_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!timeout && !busy));

  // R4: a new timeout coincides with the timer stopping
  assert_timeout_stops_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> $fell(busy));

  // R13: enabled flags reach the interrupt one cycle later
  assert_irq_timeout_R13: assert property (@(posedge clk) disable iff (rst)
    (timeout && to_ie) |=> irq);
  assert_irq_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    (!(svc_req && svc_ie) && !(timeout && to_ie) && !(overrun && ovr_ie)) |=> !irq);
endmodule

bind ir_pw_rx ir_pw_rx_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst(rst), .rx_en(rx_en), .fifo_en(fifo_en), .svc_ie(svc_ie),
  .to_ie(to_ie), .ovr_ie(ovr_ie), .rd_data(rd_data), .svc_req(svc_req),
  .timeout(timeout), .overrun(overrun), .busy(busy), .irq(irq)
);

// File: tb/ir_pw_rx_tb.sv
`timescale 1ns/1ps
module ir_pw_rx_tb;
  localparam int CNT_W = 8;
  localparam int W     = CNT_W + 2;
  localparam logic [CNT_W:0] MARKER = {1'b1, {CNT_W{1'b1}}};

  logic clk = 1'b0, rst = 1'b1;
  logic ir_in = 0, tx_loop_in = 0, loopback = 0, rx_en = 0, fifo_en = 0;
  logic [1:0] edge_sel = 2'b11, win_sel = 2'b00;
  logic demod_en = 0, no_load = 0, wm_not_empty = 0;
  logic svc_ie = 0, to_ie = 0, ovr_ie = 0, rd_en = 0;
  logic [15:0] clk_div = '0, lpf_count = '0;
  logic [W-1:0] rd_data;
  logic svc_req, timeout, overrun, busy, irq;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [CNT_W:0] expq[$];

  always #2 clk = ~clk;

  ir_pw_rx #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .ir_in(ir_in), .tx_loop_in(tx_loop_in),
    .loopback(loopback), .rx_en(rx_en), .fifo_en(fifo_en), .edge_sel(edge_sel),
    .demod_en(demod_en), .win_sel(win_sel), .clk_div(clk_div),
    .lpf_count(lpf_count), .no_load(no_load), .wm_not_empty(wm_not_empty),
    .svc_ie(svc_ie), .to_ie(to_ie), .ovr_ie(ovr_ie), .rd_en(rd_en),
    .rd_data(rd_data), .svc_req(svc_req), .timeout(timeout),
    .overrun(overrun), .busy(busy), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_word(input logic lvl, input int n);
    expq.push_back({lvl, CNT_W'(n)});
  endtask

  // monitor: pops every stored word and compares it with the scoreboard
  task automatic drain(input string req);
    int guard = 0;
    while (rd_data[W-1] && guard < 20) begin
      if (expq.size() == 0)
        check(0, req, "unexpected word", 32'(rd_data[CNT_W:0]), 0);
      else begin
        logic [CNT_W:0] e;
        e = expq.pop_front();
        check(rd_data[CNT_W:0] == e, req, "word", 32'(rd_data[CNT_W:0]), 32'(e));
      end
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      guard++;
    end
    check(expq.size() == 0, req, "missing words", 32'(expq.size()), 0);
    expq.delete();
  endtask

  task automatic restart();
    rx_en = 0; fifo_en = 0;
    repeat (3) @(negedge clk);
    rx_en = 1; fifo_en = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    ir_in = 1; repeat (hi) @(negedge clk);
    ir_in = 0; repeat (lo) @(negedge clk);
  endtask

  task automatic carrier(input int half, input int cycles);
    for (int i = 0; i < cycles; i++) pulse(half, half);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R3, R4, R7)
    check(rd_data[W-1] == 0, "R3", "valid after reset", 32'(rd_data[W-1]), 0);
    check(!timeout && !overrun && !busy && !irq, "R4", "flags after reset",
          {timeout, overrun, busy, irq}, 0);

    // R1 R3 R4 R6 R13: basic widths, both edges
    to_ie = 1;
    restart();
    pulse(40, 25); pulse(60, 20);
    expect_word(1, 9); expect_word(0, 6); expect_word(1, 14);
    check(svc_req == 0, "R6", "svc_req with 3 words", 32'(svc_req), 0);
    check(busy == 1, "R4", "busy while timing", 32'(busy), 1);
    repeat (1100) @(negedge clk);
    check(timeout == 1, "R4", "timeout after overflow", 32'(timeout), 1);
    check(busy == 0, "R4", "busy after overflow", 32'(busy), 0);
    check(svc_req == 1, "R6", "svc_req with 4 words", 32'(svc_req), 1);
    check(irq == 1, "R13", "irq from timeout", 32'(irq), 1);
    expq.push_back(MARKER);
    drain("R1");
    to_ie = 0;
    @(negedge clk);
    check(irq == 0, "R13", "irq with enables off", 32'(irq), 0);
    rx_en = 0;
    @(negedge clk);
    check(timeout == 0, "R8", "timeout cleared by rx_en", 32'(timeout), 1'b0);

    // R2: no edges selected
    edge_sel = 2'b00;
    restart();
    pulse(40, 40);
    check(busy == 0 && rd_data[W-1] == 0, "R2", "edge none busy/valid",
          {busy, rd_data[W-1]}, 0);
    // R2: rising only
    edge_sel = 2'b10;
    restart();
    pulse(20, 30); pulse(20, 20);
    expect_word(0, 12);
    repeat (1100) @(negedge clk);
    expq.push_back(MARKER);
    drain("R2");
    edge_sel = 2'b11;

    // R5 R6: no-load, watermark on any data
    no_load = 1; wm_not_empty = 1;
    restart();
    pulse(40, 20);
    check(svc_req == 1, "R6", "svc_req not-empty watermark", 32'(svc_req), 1);
    repeat (1100) @(negedge clk);
    check(timeout == 1, "R5", "timeout without load", 32'(timeout), 1);
    expect_word(1, 9);
    drain("R5");
    no_load = 0; wm_not_empty = 0;

    // R7: overrun
    ovr_ie = 1;
    restart();
    for (int i = 0; i < 10; i++) pulse(20, 20);
    check(overrun == 1, "R7", "overrun set", 32'(overrun), 1);
    check(irq == 1, "R13", "irq from overrun", 32'(irq), 1);
    for (int i = 0; i < 4; i++) begin expect_word(1, 4); expect_word(0, 4); end
    drain("R7");
    check(overrun == 1, "R7", "overrun sticky", 32'(overrun), 1);
    fifo_en = 0;
    @(negedge clk);
    fifo_en = 1;
    check(overrun == 0, "R7", "overrun cleared by fifo_en", 32'(overrun), 0);
    ovr_ie = 0;

    // R9: low-pass filter
    lpf_count = 16'd10;
    restart();
    pulse(6, 30);
    check(busy == 0, "R9", "short glitch rejected", 32'(busy), 0);
    pulse(40, 20);
    expect_word(1, 9);
    repeat (1100) @(negedge clk);
    expq.push_back(MARKER);
    drain("R9");
    lpf_count = 0;

    // R10: loopback
    loopback = 1;
    restart();
    ir_in = 1; tx_loop_in = 1;
    repeat (30) @(negedge clk);
    tx_loop_in = 0;
    repeat (20) @(negedge clk);
    ir_in = 0;
    expect_word(1, 7);
    repeat (1100) @(negedge clk);
    expq.push_back(MARKER);
    drain("R10");
    loopback = 0;

    // R11 R12: demodulation
    demod_en = 1; win_sel = 2'b00;
    restart();
    carrier(8, 10);
    expect_word(1, 36);
    repeat (1100) @(negedge clk);
    expq.push_back(MARKER);
    drain("R12");

    restart();
    carrier(6, 6);
    repeat (40) @(negedge clk);
    check(busy == 0 && rd_data[W-1] == 0, "R11", "12-tick carrier narrow window",
          {busy, rd_data[W-1]}, 0);
    win_sel = 2'b01;
    restart();
    carrier(6, 6);
    expect_word(1, 16);
    repeat (1100) @(negedge clk);
    expq.push_back(MARKER);
    drain("R11");

    win_sel = 2'b00;
    restart();
    carrier(10, 6);
    repeat (40) @(negedge clk);
    check(busy == 0 && rd_data[W-1] == 0, "R12", "20-tick carrier narrow window",
          {busy, rd_data[W-1]}, 0);
    win_sel = 2'b10;
    restart();
    carrier(10, 6);
    expect_word(1, 25);
    repeat (1100) @(negedge clk);
    expq.push_back(MARKER);
    drain("R12");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule